// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block produces the timing pulses that pace a serial transmitter and receiver. A 24-bit accumulator adds a programmable increment on every system clock. Whenever the add carries out of the top bit, the block raises a single-cycle oversample tick. Because the accumulator keeps the remainder instead of restarting from zero, the average tick rate is `inc / 2^24` of the clock rate, and any fraction of the clock can be approximated. For a clock `f` and a bit rate `B`, software loads `inc = round(8 * B * 2^24 / f)`.

The increment is held as three byte lanes: upper, middle and lower. Each lane has its own write strobe and shares one data byte. A 3-bit phase counter divides the oversample tick by eight and raises a bit strobe once per serial bit period. A receiver can clear this counter synchronously so that bit periods line up with a start edge. After reset the increment is zero, so no pulses are produced and the serial engine stays idle until software programs a rate.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `ovsTick` and `bitStrobe` are 0. The accumulator, the increment and the phase counter all reset to 0.
- R2: On every clock edge the accumulator becomes `(acc + inc) mod 2^24`. `ovsTick` is 1 for exactly the cycle that follows an edge whose add carried out of bit 23, and 0 otherwise.
- R3: The three increment lanes are independent. `wrUpper` loads `wrData` into increment bits 23:16, `wrMiddle` into bits 15:8 and `wrLower` into bits 7:0. A lane whose strobe is low keeps its value. Several strobes in the same cycle load the same byte into every selected lane.
- R4: A lane written at clock edge k is first used by the add at edge k+1. Example: from reset, writing 0x80 to the upper lane makes `ovsTick` read 0, 0, 1 in the three cycles after the write edge.
- R5: The phase counter advances by one (mod 8) on each edge at which `ovsTick` is 1 and `phaseAlign` is 0. `bitStrobe` is 1 for the one cycle after the edge that moves the counter from 7 to 0.
- R6: `phaseAlign` high at an edge clears the phase counter and forces `bitStrobe` to 0 for the next cycle. This holds even if `ovsTick` is 1 in that cycle; that tick is not counted.
- R7: With the increment zero, the accumulator holds its value and no `ovsTick` is produced.
- R8: Over a window of N cycles with a constant increment, the number of ticks is `floor(N*inc/2^24)` or one more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| wrUpper | input | 1 | Load `wrData` into increment bits 23:16 |
| wrMiddle | input | 1 | Load `wrData` into increment bits 15:8 |
| wrLower | input | 1 | Load `wrData` into increment bits 7:0 |
| wrData | input | 8 | Byte written to the selected lanes |
| phaseAlign | input | 1 | Synchronous clear of the divide-by-8 phase counter |
| ovsTick | output | 1 | One-cycle oversample tick, 8 per bit |
| bitStrobe | output | 1 | One-cycle strobe per bit period |

## Verification
Two functions can land on the same edge: the phase clear from `phaseAlign`, and the counting of an oversample tick that is high in that cycle. The bench provokes this deliberately by waiting until a tick is visible and raising `phaseAlign` for that same cycle. The collision is judged correct when the strobe stays low and the first strobe appears exactly 17 cycles later, after eight fresh ticks. Randomly timed align pulses and lane writes that overlap live ticks cover the other collisions, and an independent cycle model checks them every cycle.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int LANE_W    = 8;
  localparam int NUM_LANES = 3;
  localparam int ACC_W     = LANE_W * NUM_LANES;

  typedef struct packed {
    logic [NUM_LANES-1:0] loadLane;  // index 2 = upper, 0 = lower
    logic                 clrPhase;
  } ctlStrobes_t;
endpackage

// File: rtl/baud_acc_path.sv
module baud_acc_path
  import baud_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [LANE_W-1:0] wrData,
  output logic              tick
);
  logic [ACC_W-1:0] incReg;
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  genvar lane;
  generate
    for (lane = 0; lane < NUM_LANES; lane++) begin : g_lane
      always_ff @(posedge clk) begin
        if (!rstN)
          incReg[lane*LANE_W +: LANE_W] <= '0;
        else if (ctl.loadLane[lane])
          incReg[lane*LANE_W +: LANE_W] <= wrData;
      end

      // R3/R4: a written lane holds the written byte on the following cycle
      a_r3_lane_load: assert property (@(posedge clk) disable iff (!rstN)
        ctl.loadLane[lane] |=> incReg[lane*LANE_W +: LANE_W] == $past(wrData));
    end
  endgenerate

  always_comb sum = {1'b0, acc} + {1'b0, incReg};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc  <= '0;
      tick <= 1'b0;
    end else begin
      acc  <= sum[ACC_W-1:0];
      tick <= sum[ACC_W];
    end
  end

  // R7: zero increment can never carry
  a_r7_zero_inc_no_tick: assert property (@(posedge clk) disable iff (!rstN)
    (incReg == '0) |=> !tick);

  // R7: zero increment keeps the accumulator still
  a_r7_zero_inc_hold: assert property (@(posedge clk) disable iff (!rstN)
    (incReg == '0) |=> $stable(acc));

  // R3: no strobe, no change of the increment
  a_r3_hold_inc: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadLane == '0) |=> $stable(incReg));
endmodule

// File: rtl/baud_phase_ctl.sv
module baud_phase_ctl
  import baud_pkg::*;
#(
  parameter int OVS_RATIO = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrUpper,
  input  logic        wrMiddle,
  input  logic        wrLower,
  input  logic        phaseAlign,
  input  logic        tick,
  output ctlStrobes_t ctl,
  output logic        bitStrobe
);
  localparam int SUB_W = (OVS_RATIO > 1) ? $clog2(OVS_RATIO) : 1;
  localparam logic [SUB_W-1:0] LAST_PHASE = SUB_W'(OVS_RATIO - 1);

  logic [SUB_W-1:0] phaseCnt;

  always_comb begin
    ctl.loadLane = {wrUpper, wrMiddle, wrLower};
    ctl.clrPhase = phaseAlign;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt  <= '0;
      bitStrobe <= 1'b0;
    end else if (ctl.clrPhase) begin
      phaseCnt  <= '0;
      bitStrobe <= 1'b0;
    end else if (tick) begin
      phaseCnt  <= (phaseCnt == LAST_PHASE) ? '0 : phaseCnt + 1'b1;
      bitStrobe <= (phaseCnt == LAST_PHASE);
    end else begin
      bitStrobe <= 1'b0;
    end
  end

  // R6: align clears the phase and suppresses the strobe
  a_r6_align_clears: assert property (@(posedge clk) disable iff (!rstN)
    phaseAlign |=> (phaseCnt == '0) && !bitStrobe);

  // R5: a strobe follows a counted tick
  a_r5_strobe_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |-> $past(tick) && !$past(phaseAlign));

  // R5: a strobe coincides with the phase wrapping to zero
  a_r5_strobe_at_wrap: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |-> (phaseCnt == '0));

  // R5: with no tick and no align the phase stays put
  a_r5_phase_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !phaseAlign) |=> $stable(phaseCnt) && !bitStrobe);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int OVS_RATIO = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrUpper,
  input  logic              wrMiddle,
  input  logic              wrLower,
  input  logic [LANE_W-1:0] wrData,
  input  logic              phaseAlign,
  output logic              ovsTick,
  output logic              bitStrobe
);
  ctlStrobes_t ctl;

  baud_phase_ctl #(.OVS_RATIO(OVS_RATIO)) ctl_i (
    .clk(clk), .rstN(rstN),
    .wrUpper(wrUpper), .wrMiddle(wrMiddle), .wrLower(wrLower),
    .phaseAlign(phaseAlign), .tick(ovsTick),
    .ctl(ctl), .bitStrobe(bitStrobe)
  );

  baud_acc_path path_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData), .tick(ovsTick)
  );

  // R1: outputs are quiet on the first cycle out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rstN |=> !ovsTick && !bitStrobe);
endmodule

// File: tb/baud_tick_gen_tb_top.sv
module baud_tick_gen_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrUpper = 1'b0, wrMiddle = 1'b0, wrLower = 1'b0;
  logic [7:0] wrData = '0;
  logic       phaseAlign = 1'b0;
  logic       ovsTick, bitStrobe;

  int compared = 0;
  int mismatched = 0;
  bit lockCmp = 1'b0;

  always #5 clk = ~clk;

  baud_tick_gen dut_i (
    .clk(clk), .rstN(rstN), .wrUpper(wrUpper), .wrMiddle(wrMiddle),
    .wrLower(wrLower), .wrData(wrData), .phaseAlign(phaseAlign),
    .ovsTick(ovsTick), .bitStrobe(bitStrobe)
  );

  // Independent cycle model built from R2..R6
  logic [23:0] mAcc, mInc;
  logic        mTick, mStrobe;
  int          mPhase;

  function automatic logic [24:0] addInc(input logic [23:0] a, input logic [23:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  always @(posedge clk) begin
    logic [24:0] s;
    if (!rstN) begin
      mAcc <= '0; mInc <= '0; mTick <= 1'b0; mStrobe <= 1'b0; mPhase <= 0;
    end else begin
      s = addInc(mAcc, mInc);
      mAcc  <= s[23:0];
      mTick <= s[24];
      if (phaseAlign) begin
        mPhase <= 0; mStrobe <= 1'b0;
      end else if (mTick) begin
        mStrobe <= (mPhase == 7);
        mPhase  <= (mPhase + 1) % 8;
      end else begin
        mStrobe <= 1'b0;
      end
      if (wrUpper)  mInc[23:16] <= wrData;
      if (wrMiddle) mInc[15:8]  <= wrData;
      if (wrLower)  mInc[7:0]   <= wrData;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (lockCmp && rstN) begin
      check("R2 tick vs model", 32'(ovsTick), 32'(mTick));
      check("R5 strobe vs model", 32'(bitStrobe), 32'(mStrobe));
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    wrUpper = 0; wrMiddle = 0; wrLower = 0; phaseAlign = 0;
    repeat (3) @(negedge clk);
    check("R1 tick in reset", 32'(ovsTick), 0);
    check("R1 strobe in reset", 32'(bitStrobe), 0);
    rstN = 1'b1;
  endtask

  task automatic writeLanes(input logic u, input logic m, input logic l, input logic [7:0] d);
    @(negedge clk);
    wrUpper = u; wrMiddle = m; wrLower = l; wrData = d;
    @(negedge clk);
    wrUpper = 0; wrMiddle = 0; wrLower = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int tickCnt, lo, firstK;
    void'($urandom(32'd20240611));

    // R1 / R7: after reset, zero increment gives no ticks
    doReset();
    lockCmp = 1'b1;
    tickCnt = 0;
    repeat (200) begin
      @(negedge clk);
      if (ovsTick) tickCnt++;
    end
    check("R7 no ticks with zero increment", 32'(tickCnt), 0);

    // R4: write upper 0x80 -> tick reads 0,0,1 after write edge
    doReset();
    @(negedge clk);
    wrUpper = 1; wrData = 8'h80;
    @(negedge clk);
    wrUpper = 0;
    check("R4 first cycle after write", 32'(ovsTick), 0);
    @(negedge clk);
    check("R4 second cycle after write", 32'(ovsTick), 0);
    @(negedge clk);
    check("R4 third cycle after write", 32'(ovsTick), 1);

    // R6: align coincident with a visible tick
    @(negedge clk);
    while (!ovsTick) @(negedge clk);
    phaseAlign = 1;
    @(negedge clk);
    phaseAlign = 0;
    check("R6 strobe cleared by align", 32'(bitStrobe), 0);
    firstK = 0;
    for (int k = 1; k <= 40 && firstK == 0; k++) begin
      if (k > 1) @(negedge clk);
      if (bitStrobe) firstK = k;
    end
    check("R6 first strobe after aligned collision", 32'(firstK), 17);

    // R3: multi-lane write and single-lane overwrite (observed via model lockstep)
    writeLanes(1, 1, 1, 8'h11);
    repeat (50) @(negedge clk);
    writeLanes(0, 1, 0, 8'hF0);
    repeat (50) @(negedge clk);

    // R8: average rate over a long window
    doReset();
    writeLanes(1, 0, 0, 8'h0A);
    writeLanes(0, 1, 0, 8'h3D);
    writeLanes(0, 0, 1, 8'h71);
    tickCnt = 0;
    repeat (10000) begin
      @(negedge clk);
      if (ovsTick) tickCnt++;
    end
    lo = int'((64'd10000 * 64'h0A3D71) >> 24);
    check("R8 tick count within rounding", 32'((tickCnt == lo) || (tickCnt == lo + 1)), 1);

    // R7: setting increment back to zero stops ticks
    writeLanes(1, 1, 1, 8'h00);
    repeat (2) @(negedge clk);
    tickCnt = 0;
    repeat (100) begin
      @(negedge clk);
      if (ovsTick) tickCnt++;
    end
    check("R7 no ticks after zeroing", 32'(tickCnt), 0);

    // Random lane writes and align pulses, R2/R3/R5/R6 against model
    doReset();
    writeLanes(1, 0, 0, 8'h20);
    repeat (4000) begin
      @(negedge clk);
      wrUpper    = ($urandom_range(15) == 0);
      wrMiddle   = ($urandom_range(15) == 0);
      wrLower    = ($urandom_range(15) == 0);
      wrData     = 8'($urandom);
      phaseAlign = ($urandom_range(39) == 0);
    end
    @(negedge clk);
    wrUpper = 0; wrMiddle = 0; wrLower = 0; phaseAlign = 0;
    repeat (20) @(negedge clk);

    // Very fast rate: near-every-cycle ticks
    writeLanes(1, 1, 1, 8'hFF);
    repeat (300) @(negedge clk);

    lockCmp = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule